// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block sits beside a general-purpose timer and turns its event strobes into sticky status flags and one interrupt request. The timer supplies an update strobe, a trigger line and one event strobe for each capture/compare channel. Each source latches into its own flag bit. Software clears a flag by writing 1 to its bit. For a channel in capture mode, reading that channel's capture register also clears the flag. When a channel event arrives while the channel's flag is still set, a separate missed bit records that software fell behind.

A configuration register picks which flags may drive the interrupt. Flags latch whether or not they are picked. A global enable gates the request. It is turned on by writing 1 to a set register and turned off by writing 1 to a separate clear register. The interrupt output is a level: it stays high for as long as an enabled, picked flag is set.

Register access uses a simple strobe bus. Read data is registered and appears one cycle after the read strobe. It then holds until the next read.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After synchronous reset, every flag, missed, config and enable bit is 0, `irq` is 0 and `bus_rdata` is 0.
- R2: An `upd_evt` pulse sets the update flag, which is bit 0 of the flag register at word address 0, on the next clock edge.
- R3: With `gated_mode` = 0, a 0-to-1 change of `trig_in` sets the trigger flag, bit 1 of the flag register, on the clock edge that samples the new level, and a 1-to-0 change does not set it. With `gated_mode` = 1, a change in either direction sets it. The trigger line is taken as 0 before the first edge after reset.
- R4: A pulse on `ch_evt[i]` sets the channel flag at bit 2+i of the flag register.
- R5: A bus write to address 0 clears every flag bit whose `bus_wdata` bit is 1, and leaves bits whose `bus_wdata` bit is 0 unchanged.
- R6: A `cap_rd[i]` strobe clears the channel flag at bit 2+i only when `ch_capmode[i]` is 1. When `ch_capmode[i]` is 0 the strobe has no effect.
- R7: A `ch_evt[i]` pulse that arrives while channel i's flag is already set sets bit i of the missed register at address 1. A bus write to address 1 clears the missed bits written as 1.
- R8: The config register at address 2 can be read and written, with one bit for each flag position. `irq` equals the global enable ANDed with the OR of all flag bits ANDed with their config bits. Flags latch whatever their config bits hold.
- R9: Writing `bus_wdata[0]` = 1 to address 3 sets the global enable, and writing `bus_wdata[0]` = 1 to address 4 clears it. A write with bit 0 equal to 0 does neither. Reads of address 3 or 4 return the enable in bit 0.
- R10: When a set and a clear reach the same flag in the same cycle, whether the clear comes from a bus write or a capture read, the flag ends set. A missed bit likewise ends set when its set and its write-1 clear coincide.
- R11: A read strobe loads `bus_rdata` on the next edge with the register value from before that edge. `bus_rdata` holds between reads, and addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_evt | input | 1 | Update event pulse |
| trig_in | input | 1 | External trigger level |
| gated_mode | input | 1 | 1 = both trigger edges count |
| ch_evt | input | NCH | Per-channel capture/compare event pulse |
| ch_capmode | input | NCH | 1 = channel is in capture mode |
| cap_rd | input | NCH | Per-channel capture register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
A flag that is stuck, lost or cleared by the wrong source shows up on the very next read of address 0 or 1. That read is one cycle behind the strobe. If the flag's config bit and the enable are set, the fault also shows on `irq` in the same cycle the flag changes. A wrong priority between a clear and a set is exposed by driving both in one cycle and reading back on the following one. Errors in edge detection appear as a trigger flag that sets on the wrong transition of `trig_in`, and this is visible one read later.

// File: rtl/tirq_pkg.sv
package tirq_pkg;

    localparam int TIRQ_AW = 3;
    localparam int TIRQ_DW = 32;

    typedef enum logic [TIRQ_AW-1:0] {
        REG_FLAG  = 3'd0,
        REG_MISS  = 3'd1,
        REG_CFG   = 3'd2,
        REG_ENSET = 3'd3,
        REG_ENCLR = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic               wr;
        logic               rd;
        logic [TIRQ_AW-1:0] addr;
        logic [TIRQ_DW-1:0] wdata;
    } bus_req_t;

    // flag layout: bit 0 update, bit 1 trigger, bits 2.. channels
    localparam int FLAG_UPD  = 0;
    localparam int FLAG_TRIG = 1;
    localparam int FLAG_CH0  = 2;

    function automatic int flag_width(input int nch);
        return nch + FLAG_CH0;
    endfunction

    function automatic logic hits(input bus_req_t req, input reg_sel_e sel);
        return req.wr && (req.addr == sel);
    endfunction

endpackage

// File: rtl/tirq_trig_edge.sv
module tirq_trig_edge (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    input  logic gated_mode,
    output logic trig_evt
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= trig_in;
    end

    always_comb begin
        if (gated_mode) trig_evt = trig_in ^ prev_q;
        else            trig_evt = trig_in & ~prev_q;
    end
endmodule

// File: rtl/tirq_flag_bank.sv
module tirq_flag_bank #(
    parameter int NCH   = 4,
    parameter int NFLAG = NCH + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_evt,
    input  logic             trig_evt,
    input  logic [NCH-1:0]   ch_evt,
    input  logic [NCH-1:0]   ch_capmode,
    input  logic [NCH-1:0]   cap_rd,
    input  logic [NFLAG-1:0] flag_wclr,
    input  logic [NCH-1:0]   miss_wclr,
    output logic [NFLAG-1:0] flag_q,
    output logic [NCH-1:0]   miss_q
);
    import tirq_pkg::*;

    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;
    logic [NCH-1:0]   cap_clr;
    logic [NCH-1:0]   ch_busy;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign cap_clr[i] = cap_rd[i] & ch_capmode[i];
        assign ch_busy[i] = flag_q[FLAG_CH0 + i];
        assign set_v[FLAG_CH0 + i] = ch_evt[i];
        assign clr_v[FLAG_CH0 + i] = flag_wclr[FLAG_CH0 + i] | cap_clr[i];
    end

    assign set_v[FLAG_UPD]  = upd_evt;
    assign set_v[FLAG_TRIG] = trig_evt;
    assign clr_v[FLAG_UPD]  = flag_wclr[FLAG_UPD];
    assign clr_v[FLAG_TRIG] = flag_wclr[FLAG_TRIG];

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            miss_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_v) | set_v;
            miss_q <= (miss_q & ~miss_wclr) | (ch_evt & ch_busy);
        end
    end
endmodule

// File: rtl/tirq_regif.sv
module tirq_regif #(
    parameter int NCH   = 4,
    parameter int NFLAG = NCH + 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  tirq_pkg::bus_req_t         req,
    input  logic [NFLAG-1:0]           flag_q,
    input  logic [NCH-1:0]             miss_q,
    output logic [NFLAG-1:0]           flag_wclr,
    output logic [NCH-1:0]             miss_wclr,
    output logic [NFLAG-1:0]           cfg_q,
    output logic                       en_q,
    output logic [tirq_pkg::TIRQ_DW-1:0] rdata
);
    import tirq_pkg::*;

    logic [TIRQ_DW-1:0] rd_mux;

    assign flag_wclr = hits(req, REG_FLAG) ? req.wdata[NFLAG-1:0] : '0;
    assign miss_wclr = hits(req, REG_MISS) ? req.wdata[NCH-1:0]   : '0;

    always_comb begin
        case (req.addr)
            REG_FLAG:  rd_mux = TIRQ_DW'(flag_q);
            REG_MISS:  rd_mux = TIRQ_DW'(miss_q);
            REG_CFG:   rd_mux = TIRQ_DW'(cfg_q);
            REG_ENSET,
            REG_ENCLR: rd_mux = TIRQ_DW'(en_q);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            en_q  <= 1'b0;
            rdata <= '0;
        end else begin
            if (hits(req, REG_CFG))                     cfg_q <= req.wdata[NFLAG-1:0];
            if (hits(req, REG_ENSET) && req.wdata[0])   en_q  <= 1'b1;
            else if (hits(req, REG_ENCLR) && req.wdata[0]) en_q <= 1'b0;
            if (req.rd)                                 rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
    parameter int NCH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         upd_evt,
    input  logic                         trig_in,
    input  logic                         gated_mode,
    input  logic [NCH-1:0]               ch_evt,
    input  logic [NCH-1:0]               ch_capmode,
    input  logic [NCH-1:0]               cap_rd,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [tirq_pkg::TIRQ_AW-1:0] bus_addr,
    input  logic [tirq_pkg::TIRQ_DW-1:0] bus_wdata,
    output logic [tirq_pkg::TIRQ_DW-1:0] bus_rdata,
    output logic                         irq
);
    import tirq_pkg::*;

    localparam int NFLAG = flag_width(NCH);

    bus_req_t         req;
    logic             trig_evt;
    logic [NFLAG-1:0] flag_q;
    logic [NCH-1:0]   miss_q;
    logic [NFLAG-1:0] flag_wclr;
    logic [NCH-1:0]   miss_wclr;
    logic [NFLAG-1:0] cfg_q;
    logic             en_q;

    assign req = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, wdata: bus_wdata};

    tirq_trig_edge u_trig (
        .clk        (clk),
        .rst        (rst),
        .trig_in    (trig_in),
        .gated_mode (gated_mode),
        .trig_evt   (trig_evt)
    );

    tirq_flag_bank #(.NCH(NCH), .NFLAG(NFLAG)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .upd_evt    (upd_evt),
        .trig_evt   (trig_evt),
        .ch_evt     (ch_evt),
        .ch_capmode (ch_capmode),
        .cap_rd     (cap_rd),
        .flag_wclr  (flag_wclr),
        .miss_wclr  (miss_wclr),
        .flag_q     (flag_q),
        .miss_q     (miss_q)
    );

    tirq_regif #(.NCH(NCH), .NFLAG(NFLAG)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .flag_q    (flag_q),
        .miss_q    (miss_q),
        .flag_wclr (flag_wclr),
        .miss_wclr (miss_wclr),
        .cfg_q     (cfg_q),
        .en_q      (en_q),
        .rdata     (bus_rdata)
    );

    assign irq = en_q & (|(flag_q & cfg_q));
endmodule

// File: rtl/tirq_chk.sv
module tirq_chk #(
    parameter int NCH   = 4,
    parameter int NFLAG = NCH + 2
) (
    input logic             clk,
    input logic             rst,
    input logic             upd_evt,
    input logic [NCH-1:0]   ch_evt,
    input logic             bus_rd,
    input logic [31:0]      bus_rdata,
    input logic             irq,
    input logic [NFLAG-1:0] flag_q,
    input logic [NCH-1:0]   miss_q,
    input logic             en_q
);
    AST_UPD_SETS: assert property (@(posedge clk) disable iff (rst)
        upd_evt |=> flag_q[0]); // R2
    AST_UPD_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q[0]) |-> $past(upd_evt)); // R2
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq |-> en_q); // R9
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag_q != '0)); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> $stable(bus_rdata)); // R11

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        AST_CH_SETS: assert property (@(posedge clk) disable iff (rst)
            ch_evt[i] |=> flag_q[2+i]); // R4
        AST_CH_MISS: assert property (@(posedge clk) disable iff (rst)
            (ch_evt[i] && flag_q[2+i]) |=> miss_q[i]); // R7
    end
endmodule

bind tmr_irq_ctrl tirq_chk #(.NCH(NCH), .NFLAG(NFLAG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .upd_evt   (upd_evt),
    .ch_evt    (ch_evt),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .flag_q    (flag_q),
    .miss_q    (miss_q),
    .en_q      (en_q)
);

// File: tb/sim_tmr_irq_ctrl.sv
`timescale 1ns/1ps
module sim_tmr_irq_ctrl;
    localparam int NCH = 4;
    localparam int NF  = NCH + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic upd_evt = 1'b0, trig_in = 1'b0, gated_mode = 1'b0;
    logic [NCH-1:0] ch_evt = '0, ch_capmode = '0, cap_rd = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq;

    always #2.5 clk = ~clk;

    tmr_irq_ctrl #(.NCH(NCH)) u0 (.*);

    int n_chk = 0, n_fail = 0;
    logic [NF-1:0]  m_flag = '0, m_cfg = '0;
    logic [NCH-1:0] m_miss = '0;
    logic m_en = 1'b0, m_prev = 1'b0;

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return 32'(m_flag);
            3'd1: return 32'(m_miss);
            3'd2: return 32'(m_cfg);
            3'd3, 3'd4: return 32'(m_en);
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic tev;
        logic [NF-1:0] fset, fclr;
        logic [NCH-1:0] mclr;
        tev  = gated_mode ? (trig_in ^ m_prev) : (trig_in & ~m_prev);
        fset = {ch_evt, tev, upd_evt};
        fclr = (bus_wr && bus_addr == 3'd0) ? bus_wdata[NF-1:0] : '0;
        fclr = fclr | {cap_rd & ch_capmode, 2'b00};
        mclr = (bus_wr && bus_addr == 3'd1) ? bus_wdata[NCH-1:0] : '0;
        m_miss = (m_miss & ~mclr) | (ch_evt & m_flag[NF-1:2]);
        m_flag = (m_flag & ~fclr) | fset;
        if (bus_wr && bus_addr == 3'd2) m_cfg = bus_wdata[NF-1:0];
        if (bus_wr && bus_addr == 3'd3 && bus_wdata[0]) m_en = 1'b1;
        else if (bus_wr && bus_addr == 3'd4 && bus_wdata[0]) m_en = 1'b0;
        m_prev = trig_in;
    endtask

    // one clock: inputs already driven at a falling edge
    task automatic cyc(input string tag);
        logic [31:0] exp_rd;
        logic do_rd;
        do_rd  = bus_rd;
        exp_rd = m_read(bus_addr);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R8 irq", 32'(irq), 32'(m_en & (|(m_flag & m_cfg))));
        if (do_rd) chk(tag, bus_rdata, exp_rd);
        upd_evt = 1'b0; ch_evt = '0; cap_rd = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        bus_rd = 1'b1; bus_addr = a; cyc(tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; cyc(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 rdata", bus_rdata, 32'd0);
        for (int a = 0; a < 5; a++) rd(3'(a), "R1");
        // R2 update flag
        upd_evt = 1'b1; cyc("R2");
        rd(3'd0, "R2");
        // R5 write-one-clear
        wr(3'd0, 32'h0, "R5"); rd(3'd0, "R5");
        wr(3'd0, 32'h1, "R5"); rd(3'd0, "R5");
        // R3 trigger edges
        trig_in = 1'b1; cyc("R3"); rd(3'd0, "R3");
        wr(3'd0, 32'h2, "R3");
        trig_in = 1'b0; cyc("R3"); rd(3'd0, "R3");
        gated_mode = 1'b1; trig_in = 1'b1; cyc("R3");
        wr(3'd0, 32'h2, "R3");
        trig_in = 1'b0; cyc("R3"); rd(3'd0, "R3");
        gated_mode = 1'b0;
        wr(3'd0, 32'h3f, "R5");
        // R4 channel flags
        ch_evt = 4'b0101; cyc("R4"); rd(3'd0, "R4");
        // R7 missed
        ch_evt = 4'b0001; cyc("R7"); rd(3'd1, "R7");
        wr(3'd1, 32'h1, "R7"); rd(3'd1, "R7");
        // R6 capture read clear
        ch_capmode = 4'b0000; cap_rd = 4'b0001; cyc("R6"); rd(3'd0, "R6");
        ch_capmode = 4'b0001; cap_rd = 4'b0001; cyc("R6"); rd(3'd0, "R6");
        // R10 set beats clear
        upd_evt = 1'b1; wr(3'd0, 32'h3f, "R10"); rd(3'd0, "R10");
        ch_evt = 4'b0100; cap_rd = 4'b0100; ch_capmode = 4'b0100; cyc("R10"); rd(3'd0, "R10");
        ch_evt = 4'b0100; wr(3'd1, 32'hf, "R10"); rd(3'd1, "R10");
        // R8 config and irq
        wr(3'd2, 32'h01, "R8"); rd(3'd2, "R8");
        wr(3'd3, 32'h0, "R9"); rd(3'd3, "R9");
        wr(3'd3, 32'h1, "R9"); rd(3'd4, "R9");
        wr(3'd2, 32'h00, "R8");
        wr(3'd2, 32'h10, "R8");
        wr(3'd4, 32'h1, "R9"); rd(3'd3, "R9");
        // R11 unused addresses and hold
        for (int a = 5; a < 8; a++) rd(3'(a), "R11");
        cyc("R11"); chk("R11 hold", bus_rdata, 32'd0);
        // random phase
        for (int k = 0; k < 4000; k++) begin
            upd_evt    = ($urandom % 8) == 0;
            trig_in    = ($urandom % 4) == 0 ? ~trig_in : trig_in;
            gated_mode = ($urandom % 64) == 0 ? ~gated_mode : gated_mode;
            ch_evt     = 4'($urandom) & 4'($urandom) & 4'($urandom);
            ch_capmode = ($urandom % 16) == 0 ? 4'($urandom) : ch_capmode;
            cap_rd     = 4'($urandom) & 4'($urandom);
            bus_wr     = ($urandom % 3) == 0;
            bus_rd     = ($urandom % 2) == 0;
            bus_addr   = 3'($urandom);
            bus_wdata  = $urandom;
            cyc("R11 random read");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule